// File: doc/BRIEF.md
# Single-Channel DMA Controller with One-Shot and Auto-Reload Modes

This block is one DMA channel. Software sets it up through a small register port. The settings are a source pointer, a destination pointer, a transfer-count reload value, a direction choice and a mode. The mode is one-shot or auto-reload. A select field picks one trigger line. The candidates are a vector of peripheral and external interrupt request lines, plus a software trigger that is reached through the register port.

A rising edge on the selected line latches a pending-request flag. The flag latches whether or not the channel is enabled. When the channel is enabled and idle and the flag is set, the channel clears the flag and makes one transfer. A transfer is a read from the source address followed by a write of that word to the destination address. Both go over a valid/ready memory master port.

One pointer is chosen as the forward pointer, and only that pointer advances. A down counter counts the transfers. In one-shot mode the counter underflowing switches the channel off. In auto-reload mode the counter underflowing reloads both the counter and the forward pointer, and the channel runs until software switches it off. Writing the enable bit as 1 arms a reload of the counter and the forward pointer, and that reload happens when the next transfer starts. This holds even while the channel is running, so the channel starts over from its initial state.

Top module: `dma_chan`

## Requirements
- R1: The pending flag becomes 1 on a rising edge of the selected trigger. It does so whether the channel is enabled or not. A select value s below 7 picks `req_in[s]`. Select value 7 picks the software trigger, which is a register write to address 7 with bit 0 set.
- R2: The hardware clears the pending flag in the cycle the channel begins a transfer. A trigger edge in that same cycle wins, and the flag stays 1.
- R3: A register write to address 4 with bit 0 = 0 clears the pending flag. A write there with bit 0 = 1 leaves the flag as it was.
- R4: The trigger line is edge-detected after the select multiplexer. Changing the select field to a line that is already high therefore sets the pending flag.
- R5: A transfer begins only when three things hold: the enable bit is 1, the pending flag is 1, and the master port is idle. The transfer is one read from the source address, then one write of the returned word to the destination address. The port then spends one cycle with valid low.
- R6: Back-pressure: while `mem_valid` is 1 and `mem_ready` is 0, the port holds `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` unchanged. A beat completes only in a cycle where both valid and ready are 1.
- R7: Control bit 2 chooses the forward pointer: 0 makes the source pointer forward, 1 makes the destination pointer forward. After each transfer, only the forward pointer advances by 1. The other address stays fixed.
- R8: A reload value N gives N+1 transfers before the counter underflows. In one-shot mode (control bit 1 = 0), the underflow clears the enable bit, and the counter then reads all ones.
- R9: In auto-reload mode (control bit 1 = 1), the underflow reloads the counter from the reload register. It also reloads the forward pointer from its base register. The channel stays enabled until software writes 0 to the enable bit.
- R10: Any write to the control register with bit 0 = 1 arms a reload of the forward pointer and the counter. The reload is applied when the next transfer starts. This includes the case where the channel is already active.
- R11: Register map. Address 0 is control: bit 0 enable, bit 1 mode, bit 2 forward select, bits 10:8 trigger select. Address 1 is the source pointer, 2 the destination pointer and 3 the reload value. Address 4 is the pending flag (bit 0). Address 5 is the counter and address 6 the forward pointer; both are read-only. Address 7 is write-only. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_addr` |
| req_in | input | 7 | Peripheral and external trigger lines |
| mem_valid | output | 1 | Master beat valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 16 | Beat address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ready` on a read beat |

## Verification
The one-shot path is driven from a vector table. The table mixes source-forward and destination-forward setups with reload values of 0, 2, 3 and 5. The word left at the destination, and the final pointer, show which pointer advanced and how many transfers ran. One extra trigger after underflow shows that the channel really stopped while the flag still latches. An auto-reload run of five triggers with reload 1 checks the memory after the fourth and after the fifth transfer. That separates a pointer that wraps back to its base from one that keeps counting up. A restart issued after two transfers shows whether the reload is applied again when the channel is already active. Directed tests also hold `mem_ready` low, change the select onto a line that is already high, and write 1 to the flag.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_READ = 2'd1,
    XS_WRITE = 2'd2
  } xfer_state_t;

  localparam int unsigned REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] RA_SRC   = 3'd1;
  localparam logic [REG_AW-1:0] RA_DST   = 3'd2;
  localparam logic [REG_AW-1:0] RA_RLD   = 3'd3;
  localparam logic [REG_AW-1:0] RA_FLAG  = 3'd4;
  localparam logic [REG_AW-1:0] RA_CNT   = 3'd5;
  localparam logic [REG_AW-1:0] RA_FWD   = 3'd6;
  localparam logic [REG_AW-1:0] RA_SWTRG = 3'd7;

  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_RPT  = 1;
  localparam int unsigned CB_FDST = 2;
  localparam int unsigned CB_SEL  = 8;

endpackage

// File: rtl/dma_chan_trig.sv
module dma_chan_trig #(
  parameter int unsigned NREQ  = 7,
  parameter int unsigned SEL_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req_in,
  input  logic            sw_pulse,
  input  logic [SEL_W-1:0] sel,
  input  logic            hw_clr,
  input  logic            sw_clr,
  output logic            flag_q
);
  localparam int unsigned NSRC = NREQ + 1;

  logic [NSRC-1:0] src_vec;
  logic            line;
  logic            line_prev_q;
  logic            rise;

  assign src_vec = {sw_pulse, req_in};

  always_comb begin
    line = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel == SEL_W'(i)) line = src_vec[i];
    end
  end

  assign rise = line & ~line_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_prev_q <= 1'b0;
      flag_q      <= 1'b0;
    end else begin
      line_prev_q <= line;
      if (rise) flag_q <= 1'b1;
      else if (hw_clr || sw_clr) flag_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int unsigned REG_W  = 16,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              start,
  input  logic              single_done,
  input  logic              flag,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [ADDR_W-1:0] fwd,
  output logic              en_q,
  output logic              rpt_q,
  output logic              fdst_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [CNT_W-1:0]  rld_q,
  output logic              pend_q,
  output logic              sw_pulse,
  output logic              sw_clr
);
  logic wr_ctrl;
  logic unused_wdata;

  assign wr_ctrl  = cfg_wr && (cfg_addr == RA_CTRL);
  assign sw_pulse = cfg_wr && (cfg_addr == RA_SWTRG) && cfg_wdata[0];
  assign sw_clr   = cfg_wr && (cfg_addr == RA_FLAG) && !cfg_wdata[0];
  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      rpt_q  <= 1'b0;
      fdst_q <= 1'b0;
      sel_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      rld_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= cfg_wdata[CB_EN];
        rpt_q  <= cfg_wdata[CB_RPT];
        fdst_q <= cfg_wdata[CB_FDST];
        sel_q  <= cfg_wdata[CB_SEL +: SEL_W];
      end else if (single_done) begin
        en_q <= 1'b0;
      end
      if (wr_ctrl && cfg_wdata[CB_EN]) pend_q <= 1'b1;
      else if (start) pend_q <= 1'b0;
      if (cfg_wr && cfg_addr == RA_SRC) src_q <= cfg_wdata[ADDR_W-1:0];
      if (cfg_wr && cfg_addr == RA_DST) dst_q <= cfg_wdata[ADDR_W-1:0];
      if (cfg_wr && cfg_addr == RA_RLD) rld_q <= cfg_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      RA_CTRL: begin
        cfg_rdata[CB_EN]           = en_q;
        cfg_rdata[CB_RPT]          = rpt_q;
        cfg_rdata[CB_FDST]         = fdst_q;
        cfg_rdata[CB_SEL +: SEL_W] = sel_q;
      end
      RA_SRC:  cfg_rdata = REG_W'(src_q);
      RA_DST:  cfg_rdata = REG_W'(dst_q);
      RA_RLD:  cfg_rdata = REG_W'(rld_q);
      RA_FLAG: cfg_rdata = REG_W'(flag);
      RA_CNT:  cfg_rdata = REG_W'(cnt);
      RA_FWD:  cfg_rdata = REG_W'(fwd);
      default: cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rpt,
  input  logic              fdst,
  input  logic              flag,
  input  logic              pend,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic [CNT_W-1:0]  rld,
  output logic              start,
  output logic              single_done,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [ADDR_W-1:0] fwd_q,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  xfer_state_t       st_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] base;
  logic              wr_done;
  logic              underflow;

  assign base        = fdst ? dst : src;
  assign start       = (st_q == XS_IDLE) && en && flag;
  assign wr_done     = (st_q == XS_WRITE) && mem_ready;
  assign underflow   = (cnt_q == '0);
  assign single_done = wr_done && underflow && !rpt;

  assign mem_valid = (st_q != XS_IDLE);
  assign mem_we    = (st_q == XS_WRITE);
  assign mem_wdata = data_q;

  always_comb begin
    if (st_q == XS_WRITE) mem_addr = fdst ? fwd_q : dst;
    else                  mem_addr = fdst ? src : fwd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= XS_IDLE;
      data_q <= '0;
      cnt_q  <= '0;
      fwd_q  <= '0;
    end else begin
      case (st_q)
        XS_IDLE: begin
          if (start) begin
            st_q <= XS_READ;
            if (pend) begin
              fwd_q <= base;
              cnt_q <= rld;
            end
          end
        end
        XS_READ: begin
          if (mem_ready) begin
            data_q <= mem_rdata;
            st_q   <= XS_WRITE;
          end
        end
        XS_WRITE: begin
          if (mem_ready) begin
            st_q <= XS_IDLE;
            if (underflow && rpt) begin
              fwd_q <= base;
              cnt_q <= rld;
            end else begin
              fwd_q <= fwd_q + ADDR_W'(1);
              cnt_q <= cnt_q - CNT_W'(1);
            end
          end
        end
        default: st_q <= XS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int unsigned NREQ   = 7,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic [NREQ-1:0]   req_in,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int unsigned SEL_W = $clog2(NREQ + 1);

  logic              en_q, rpt_q, fdst_q, pend_q, flag_q;
  logic              start, single_done, sw_pulse, sw_clr;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] src_q, dst_q, fwd_q;
  logic [CNT_W-1:0]  rld_q, cnt_q;

  dma_chan_regs #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SEL_W(SEL_W)
  ) i_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .start(start), .single_done(single_done), .flag(flag_q), .cnt(cnt_q), .fwd(fwd_q),
    .en_q(en_q), .rpt_q(rpt_q), .fdst_q(fdst_q), .sel_q(sel_q),
    .src_q(src_q), .dst_q(dst_q), .rld_q(rld_q), .pend_q(pend_q),
    .sw_pulse(sw_pulse), .sw_clr(sw_clr)
  );

  dma_chan_trig #(.NREQ(NREQ), .SEL_W(SEL_W)) i_trig (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .sw_pulse(sw_pulse), .sel(sel_q),
    .hw_clr(start), .sw_clr(sw_clr), .flag_q(flag_q)
  );

  dma_chan_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_engine (
    .clk(clk), .rst_n(rst_n),
    .en(en_q), .rpt(rpt_q), .fdst(fdst_q), .flag(flag_q), .pend(pend_q),
    .src(src_q), .dst(dst_q), .rld(rld_q),
    .start(start), .single_done(single_done), .cnt_q(cnt_q), .fwd_q(fwd_q),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [2:0]        cfg_addr,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              en_q,
  input logic              rpt_q,
  input logic              flag_q,
  input logic [CNT_W-1:0]  cnt_q
);

  assert_hold_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  assert_read_then_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && !mem_we |=> mem_valid && mem_we);

  assert_gap_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && mem_we |=> !mem_valid);

  assert_start_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> $past(en_q && flag_q) && !mem_we);

  assert_single_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && mem_we && (cnt_q == '0) && !rpt_q && !cfg_wr |=> !en_q);

  assert_repeat_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && rpt_q && !(cfg_wr && cfg_addr == 3'd0) |=> en_q);

endmodule

bind dma_chan dma_chan_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .en_q(en_q), .rpt_q(rpt_q), .flag_q(flag_q), .cnt_q(cnt_q)
);

// File: tb/test_dma_chan.sv
module test_dma_chan;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [6:0]  req_in = '0;
  logic        mem_valid, mem_we, mem_ready = 1'b1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  logic [15:0] mem [256];
  logic        init_req = 1'b0;
  int          wr_cnt = 0;
  int          errors = 0;
  int          checks = 0;
  bit          done = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_chan i_dma_chan (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_in(req_in),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] pat(input logic [7:0] a);
    return {a, ~a};
  endfunction

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(8'(i));
    end else if (mem_valid && mem_ready && mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  // fields: [31:24] forward-is-destination, [23:16] src, [15:8] dst, [7:0] reload
  localparam logic [31:0] VEC [4] = '{
    32'h00_10_80_03, 32'h01_20_90_02, 32'h00_40_C0_00, 32'h01_05_A0_05
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic mem_init();
    @(negedge clk); init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
  endtask

  task automatic trig();
    wr(3'd7, 16'h0001);
    repeat (6) @(posedge clk);
  endtask

  function automatic logic [15:0] ctrl(input bit en, input bit rpt, input bit fdst, input logic [2:0] sel);
    return {5'd0, sel, 5'd0, fdst, rpt, en};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int base_w;
    repeat (3) @(posedge clk);
    #1 chk(mem_valid == 1'b0, "R5 reset idle", 32'(mem_valid), 0);
    rst_n = 1'b1;
    rd(3'd0, v); chk(v == 16'h0, "R11 reset ctrl", 32'(v), 0);
    rd(3'd4, v); chk(v == 16'h0, "R1 reset flag", 32'(v), 0);
    mem_init();

    // table: one-shot mode, several pointer setups
    for (int k = 0; k < 4; k++) begin
      logic fd;
      logic [7:0] s, d, r;
      fd = VEC[k][24]; s = VEC[k][23:16]; d = VEC[k][15:8]; r = VEC[k][7:0];
      mem_init();
      wr(3'd4, 16'h0000);
      wr(3'd1, {8'd0, s}); wr(3'd2, {8'd0, d}); wr(3'd3, {8'd0, r});
      base_w = wr_cnt;
      wr(3'd0, ctrl(1, 0, fd, 3'd7));
      repeat (4) @(posedge clk);
      chk(wr_cnt == base_w, "R5 no transfer without flag", 32'(wr_cnt - base_w), 0);
      for (int t = 0; t <= int'(r); t++) trig();
      chk(wr_cnt - base_w == int'(r) + 1, "R8 transfer count", 32'(wr_cnt - base_w), 32'(r) + 1);
      rd(3'd0, v); chk(v[0] == 1'b0, "R8 enable cleared", 32'(v[0]), 0);
      rd(3'd5, v); chk(v == 16'hFFFF, "R8 counter all ones", 32'(v), 32'hFFFF);
      if (fd) begin
        chk(mem[d] == pat(s) && mem[8'(d + r)] == pat(s), "R7 dst forward data",
            32'(mem[8'(d + r)]), 32'(pat(s)));
        rd(3'd6, v); chk(v == 16'(d) + 16'(r) + 16'd1, "R7 dst forward ptr", 32'(v), 32'(d) + 32'(r) + 1);
      end else begin
        chk(mem[d] == pat(8'(s + r)), "R7 src forward data", 32'(mem[d]), 32'(pat(8'(s + r))));
        chk(mem[8'(d + 1)] == pat(8'(d + 1)), "R7 dst fixed", 32'(mem[8'(d + 1)]), 32'(pat(8'(d + 1))));
        rd(3'd6, v); chk(v == 16'(s) + 16'(r) + 16'd1, "R7 src forward ptr", 32'(v), 32'(s) + 32'(r) + 1);
      end
      base_w = wr_cnt;
      trig();
      chk(wr_cnt == base_w, "R8 stopped after underflow", 32'(wr_cnt - base_w), 0);
      rd(3'd4, v); chk(v[0] == 1'b1, "R1 flag latches while disabled", 32'(v[0]), 1);
    end

    // R3: software write semantics on the flag
    wr(3'd4, 16'h0001);
    rd(3'd4, v); chk(v[0] == 1'b1, "R3 write 1 keeps flag", 32'(v[0]), 1);
    wr(3'd4, 16'h0000);
    rd(3'd4, v); chk(v[0] == 1'b0, "R3 write 0 clears", 32'(v[0]), 0);
    wr(3'd4, 16'h0001);
    rd(3'd4, v); chk(v[0] == 1'b0, "R3 write 1 does not set", 32'(v[0]), 0);

    // R1: hardware line, disabled channel
    wr(3'd0, ctrl(0, 0, 0, 3'd3));
    @(negedge clk) req_in[3] = 1'b1;
    @(negedge clk) req_in[3] = 1'b0;
    rd(3'd4, v); chk(v[0] == 1'b1, "R1 req line sets flag", 32'(v[0]), 1);
    wr(3'd4, 16'h0000);

    // R4: select change onto a high line
    wr(3'd0, ctrl(0, 0, 0, 3'd0));
    @(negedge clk) req_in[2] = 1'b1;
    repeat (3) @(posedge clk);
    rd(3'd4, v); chk(v[0] == 1'b0, "R4 unselected line ignored", 32'(v[0]), 0);
    wr(3'd0, ctrl(0, 0, 0, 3'd2));
    rd(3'd4, v); chk(v[0] == 1'b1, "R4 select change sets flag", 32'(v[0]), 1);
    @(negedge clk) req_in[2] = 1'b0;
    wr(3'd4, 16'h0000);

    // R9: auto-reload
    mem_init();
    wr(3'd1, 16'h0050); wr(3'd2, 16'h00D0); wr(3'd3, 16'h0001);
    base_w = wr_cnt;
    wr(3'd0, ctrl(1, 1, 0, 3'd7));
    for (int t = 0; t < 4; t++) trig();
    chk(mem[8'hD0] == pat(8'h51), "R9 fourth transfer", 32'(mem[8'hD0]), 32'(pat(8'h51)));
    trig();
    chk(mem[8'hD0] == pat(8'h50), "R9 pointer reloaded", 32'(mem[8'hD0]), 32'(pat(8'h50)));
    chk(wr_cnt - base_w == 5, "R9 five transfers", 32'(wr_cnt - base_w), 5);
    rd(3'd0, v); chk(v[0] == 1'b1, "R9 stays enabled", 32'(v[0]), 1);
    rd(3'd5, v); chk(v == 16'h0000, "R9 counter reloaded", 32'(v), 0);
    rd(3'd6, v); chk(v == 16'h0051, "R9 forward ptr", 32'(v), 32'h51);
    wr(3'd0, ctrl(0, 1, 0, 3'd7));
    base_w = wr_cnt;
    trig();
    chk(wr_cnt == base_w, "R9 software stop", 32'(wr_cnt - base_w), 0);
    wr(3'd4, 16'h0000);

    // R10: restart while active
    mem_init();
    wr(3'd1, 16'h0030); wr(3'd2, 16'h00B0); wr(3'd3, 16'h0005);
    wr(3'd0, ctrl(1, 0, 0, 3'd7));
    trig(); trig();
    chk(mem[8'hB0] == pat(8'h31), "R10 before restart", 32'(mem[8'hB0]), 32'(pat(8'h31)));
    wr(3'd0, ctrl(1, 0, 0, 3'd7));
    trig();
    chk(mem[8'hB0] == pat(8'h30), "R10 restart data", 32'(mem[8'hB0]), 32'(pat(8'h30)));
    rd(3'd5, v); chk(v == 16'h0004, "R10 restart count", 32'(v), 4);
    rd(3'd6, v); chk(v == 16'h0031, "R10 restart ptr", 32'(v), 32'h31);
    wr(3'd0, ctrl(0, 0, 0, 3'd7));
    wr(3'd4, 16'h0000);

    // R6 / R2: back-pressure and hardware flag clear
    mem_init();
    wr(3'd1, 16'h0060); wr(3'd2, 16'h00E0); wr(3'd3, 16'h0000);
    @(negedge clk) mem_ready = 1'b0;
    wr(3'd0, ctrl(1, 0, 0, 3'd7));
    wr(3'd7, 16'h0001);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(mem_valid && !mem_we && mem_addr == 16'h0060, "R6 read held",
        {15'd0, mem_valid, mem_addr}, {16'd1, 16'h0060});
    rd(3'd4, v); chk(v[0] == 1'b0, "R2 flag cleared at start", 32'(v[0]), 0);
    @(negedge clk) mem_ready = 1'b1;
    repeat (6) @(posedge clk);
    chk(mem[8'hE0] == pat(8'h60), "R6 data after stall", 32'(mem[8'hE0]), 32'(pat(8'h60)));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule